// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block writes a run of bytes into one 64 KiB region of a byte-wide flash device and then reads every byte back to confirm it. A request gives a start byte address and a byte count. The count is trimmed so the run never crosses the end of the 64 KiB region. The bytes arrive on a valid/ready stream. The block talks to the flash through a command bus that only carries word-aligned addresses. A separate 2-bit lane register selects the byte within the word. A one-cycle write-gate pulse must open the write path before each group of commands.

Each byte is programmed with a fixed command sequence, and the block then polls a status byte. If the status poll times out, the byte is retried without limit and without reporting an error. If the device reports a program failure, the byte is retried after a short pause for as long as a deadline counted from the start of the request has not run out. Once the deadline has passed, the request ends with an error flag.

After the last byte and a settle delay, the block asks the stream source to replay the same bytes. It then compares each replayed byte with a flash read. The result is the clipped count on a full match, zero on the first mismatch, or zero with the error flag set. The result is presented with a one-cycle done pulse.

Top module: `fbp_seq`

## Requirements
- R1: The effective count is the requested count limited to 65536 minus the low 16 bits of the start address. No byte past the end of that 64 KiB region is touched.
- R2: Every flash write uses an address whose two low bits are zero. Before the program command, the lane register is written with the two low bits of the current byte address, so each byte lands at its exact byte address.
- R3: Each program attempt does the following, in order: a read at the command offset (0x8000), a gate pulse, a lane register write, the program command 0x40 to the aligned address, and then the data byte to the aligned address. No 0x40, 0xFF or 0x50 command is issued without a gate pulse since the previous one of those commands.
- R4: After the data byte, the block writes 0x70 at the status offset (0x10000). It then reads the command offset every cycle until bit 7 of the returned byte is 1.
- R5: If bit 7 is not seen within STAT_TO poll cycles, the block pulses the gate, writes 0x50 at the command offset, and retries the same byte. This retry has no limit and never raises the error flag.
- R6: When bit 7 is seen, the block pulses the gate and writes 0xFF at the command offset, which returns the device to read mode.
- R7: If bit 4 of that ready status is 1, the block pulses the gate and writes 0x50 at the command offset. If the request deadline has not passed, it waits RETRY_WAIT cycles and retries the same byte.
- R8: The deadline counts BLK_TO busy cycles from the start of the request, across all bytes. On a bit-4 failure after the deadline has passed, the request ends with res_err = 1 and res_count = 0.
- R9: After the last byte, src_rewind pulses for one cycle. After SETTLE cycles, each byte is taken again from the stream and compared with a flash read at its byte address. The first mismatch ends the request with res_count = 0 and res_err = 0.
- R10: When every byte matches, res_count equals the effective count and res_err = 0.
- R11: busy is high from the cycle after start until the result is presented. done is a single-cycle pulse with busy low. in_ready is only high while busy.
- R12: When the effective count is zero, done follows start on the next cycle with res_count = 0, and there is no flash traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a request (sampled while idle) |
| start_addr | input | ADDR_W | First byte address |
| req_count | input | BLK_BITS+1 | Requested byte count |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| src_rewind | output | 1 | Source must restart the stream from its first byte |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read byte, valid in the cycle fl_re is high |
| gate_pulse | output | 1 | One-cycle write-gate open pulse |
| lane_wr | output | 1 | Write strobe for the lane register |
| lane_val | output | 2 | Byte lane value for the lane register |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| res_count | output | BLK_BITS+1 | Bytes written, or zero |
| res_err | output | 1 | Request ended on the deadline |

## Verification
The bench builds the block with a 17-bit address, a 20-cycle status timeout, a 400-cycle request deadline, a 4-cycle retry pause and a 3-cycle settle delay. These small values put the status timeout, repeated bit-4 failures and the expiry of the deadline within a few hundred cycles. The flash model can hold back the ready bit or report failures for a chosen number of attempts, and it can corrupt one programmed byte. This lets the bench reach each retry path and the verify mismatch. A region-end start address exercises the clip.

// File: rtl/fbp_pkg.sv
// Shared types and constants for the flash byte program sequencer.
// Assumes a byte-wide flash command set with status bits 7 (ready) and 4 (fail).
package fbp_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_FETCH, S_DUMMY, S_GATE_P, S_LANE, S_CMD, S_DATA, S_STAT,
        S_POLL, S_GATE_TO, S_TO_CLR, S_GATE_RD, S_RD_MODE, S_GATE_ER,
        S_ER_CLR, S_WAIT, S_REWIND, S_SETTLE, S_VFETCH, S_VREAD, S_FIN
    } state_t;

    localparam logic [7:0] OP_PROGRAM = 8'h40;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_READ    = 8'hFF;
    localparam int READY_BIT = 7;
    localparam int FAIL_BIT  = 4;
endpackage

// File: rtl/fbp_timer.sv
// Saturating up-counter with a run-time limit.
// Assumes clr has priority over en; hit is high once cnt reaches limit.
module fbp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = (cnt_q >= limit);

    // Count enabled cycles, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (en && !hit)
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/fbp_clip.sv
// Limits a byte count so a run never leaves its 2**BB-byte region.
// Assumes blk_off is the offset of the first byte inside the region.
module fbp_clip #(
    parameter int BB = 16
) (
    input  logic [BB-1:0] blk_off,
    input  logic [BB:0]   req,
    output logic [BB:0]   eff
);
    logic [BB:0] room;

    // Bytes left between the start offset and the region end.
    always_comb begin
        room = (BB+1)'(1 << BB) - {1'b0, blk_off};
        eff  = (req > room) ? room : req;
    end
endmodule

// File: rtl/fbp_lane_split.sv
// Splits a byte address into a word-aligned bus address and a byte lane.
// Assumes 4-byte words on the command bus.
module fbp_lane_split #(
    parameter int AW = 22
) (
    input  logic [AW-1:0] byte_addr,
    output logic [AW-1:0] word_addr,
    output logic [1:0]    lane
);
    // Clear the low bits for the bus and keep them as the lane.
    always_comb begin
        word_addr = {byte_addr[AW-1:2], 2'b00};
        lane      = byte_addr[1:0];
    end
endmodule

// File: rtl/fbp_seq.sv
// Flash byte program sequencer: programs a clipped run of stream bytes with
// per-byte status polling and retries, then verifies against a replayed stream.
// Assumes fl_rdata is valid combinationally in the cycle fl_re is high, and the
// source restarts its stream when src_rewind pulses.
module fbp_seq #(
    parameter int          ADDR_W     = 22,
    parameter int          BLK_BITS   = 16,
    parameter int unsigned CMD_OFS    = 32'h8000,
    parameter int unsigned STAT_OFS   = 32'h10000,
    parameter int unsigned STAT_TO    = 50_000_000,
    parameter int unsigned BLK_TO     = 1_500_000_000,
    parameter int unsigned RETRY_WAIT = 500_000,
    parameter int unsigned SETTLE     = 500_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [BLK_BITS:0]   req_count,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    output logic                in_ready,
    output logic                src_rewind,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [7:0]          fl_wdata,
    output logic                fl_we,
    output logic                fl_re,
    input  logic [7:0]          fl_rdata,
    output logic                gate_pulse,
    output logic                lane_wr,
    output logic [1:0]          lane_val,
    output logic                busy,
    output logic                done,
    output logic [BLK_BITS:0]   res_count,
    output logic                res_err
);
    import fbp_pkg::*;

    localparam int CW = BLK_BITS + 1;
    localparam int unsigned TMAX_A = (STAT_TO > RETRY_WAIT) ? STAT_TO : RETRY_WAIT;
    localparam int unsigned TMAX   = (TMAX_A > SETTLE) ? TMAX_A : SETTLE;
    localparam int TW = $clog2(TMAX + 1);
    localparam int DW = $clog2(BLK_TO + 1);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    state_t              state_q;
    logic [CW-1:0]       idx_q, cnt_q;
    logic [ADDR_W-1:0]   base_q;
    logic [7:0]          byte_q;
    logic                fail_q;
    logic [CW-1:0]       eff_count;
    logic [ADDR_W-1:0]   cur_addr, word_addr;
    logic                last;
    logic                tmr_en, tmr_hit, dl_hit;
    logic [TW-1:0]       tmr_limit;

    assign cur_addr = base_q + ADDR_W'(idx_q);
    assign last     = ((idx_q + CW'(1)) == cnt_q);

    fbp_clip #(.BB(BLK_BITS)) u_clip (
        .blk_off (start_addr[BLK_BITS-1:0]),
        .req     (req_count),
        .eff     (eff_count)
    );

    fbp_lane_split #(.AW(ADDR_W)) u_split (
        .byte_addr (cur_addr),
        .word_addr (word_addr),
        .lane      (lane_val)
    );

    // Pick the wait length for the state that is timing.
    always_comb begin
        tmr_en = (state_q == S_POLL) || (state_q == S_WAIT) || (state_q == S_SETTLE);
        case (state_q)
            S_POLL:  tmr_limit = TW'(STAT_TO - 1);
            S_WAIT:  tmr_limit = TW'(RETRY_WAIT - 1);
            default: tmr_limit = TW'(SETTLE - 1);
        endcase
    end

    fbp_timer #(.W(TW)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!tmr_en),
        .en    (tmr_en),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    fbp_timer #(.W(DW)) u_deadline (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_IDLE),
        .en    (busy),
        .limit (DW'(BLK_TO)),
        .hit   (dl_hit)
    );

    // Sequence control and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            cnt_q     <= '0;
            base_q    <= '0;
            byte_q    <= '0;
            fail_q    <= 1'b0;
            res_count <= '0;
            res_err   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    base_q  <= start_addr;
                    cnt_q   <= eff_count;
                    idx_q   <= '0;
                    res_err <= 1'b0;
                    if (eff_count == '0) begin
                        res_count <= '0;
                        state_q   <= S_FIN;
                    end else begin
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: if (in_valid) begin
                    byte_q  <= in_data;
                    state_q <= S_DUMMY;
                end
                S_DUMMY:  state_q <= S_GATE_P;
                S_GATE_P: state_q <= S_LANE;
                S_LANE:   state_q <= S_CMD;
                S_CMD:    state_q <= S_DATA;
                S_DATA:   state_q <= S_STAT;
                S_STAT:   state_q <= S_POLL;
                S_POLL: begin
                    if (fl_rdata[READY_BIT]) begin
                        fail_q  <= fl_rdata[FAIL_BIT];
                        state_q <= S_GATE_RD;
                    end else if (tmr_hit) begin
                        state_q <= S_GATE_TO;
                    end
                end
                S_GATE_TO: state_q <= S_TO_CLR;
                S_TO_CLR:  state_q <= S_DUMMY;
                S_GATE_RD: state_q <= S_RD_MODE;
                S_RD_MODE: begin
                    if (fail_q) begin
                        state_q <= S_GATE_ER;
                    end else if (last) begin
                        state_q <= S_REWIND;
                    end else begin
                        idx_q   <= idx_q + CW'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_GATE_ER: state_q <= S_ER_CLR;
                S_ER_CLR: begin
                    if (dl_hit) begin
                        res_err   <= 1'b1;
                        res_count <= '0;
                        state_q   <= S_FIN;
                    end else begin
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: if (tmr_hit) state_q <= S_DUMMY;
                S_REWIND: begin
                    idx_q   <= '0;
                    state_q <= S_SETTLE;
                end
                S_SETTLE: if (tmr_hit) state_q <= S_VFETCH;
                S_VFETCH: if (in_valid) begin
                    byte_q  <= in_data;
                    state_q <= S_VREAD;
                end
                S_VREAD: begin
                    if (fl_rdata != byte_q) begin
                        res_count <= '0;
                        state_q   <= S_FIN;
                    end else if (last) begin
                        res_count <= cnt_q;
                        state_q   <= S_FIN;
                    end else begin
                        idx_q   <= idx_q + CW'(1);
                        state_q <= S_VFETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Bus, gate, lane and handshake outputs decoded from the state.
    always_comb begin
        fl_addr    = '0;
        fl_wdata   = '0;
        fl_we      = 1'b0;
        fl_re      = 1'b0;
        gate_pulse = 1'b0;
        lane_wr    = 1'b0;
        in_ready   = (state_q == S_FETCH) || (state_q == S_VFETCH);
        src_rewind = (state_q == S_REWIND);
        done       = (state_q == S_FIN);
        busy       = (state_q != S_IDLE) && (state_q != S_FIN);
        case (state_q)
            S_DUMMY, S_POLL: begin
                fl_re   = 1'b1;
                fl_addr = A_CMD;
            end
            S_GATE_P, S_GATE_TO, S_GATE_RD, S_GATE_ER: gate_pulse = 1'b1;
            S_LANE: lane_wr = 1'b1;
            S_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = word_addr;
                fl_wdata = OP_PROGRAM;
            end
            S_DATA: begin
                fl_we    = 1'b1;
                fl_addr  = word_addr;
                fl_wdata = byte_q;
            end
            S_STAT: begin
                fl_we    = 1'b1;
                fl_addr  = A_STAT;
                fl_wdata = OP_STATUS;
            end
            S_TO_CLR, S_ER_CLR: begin
                fl_we    = 1'b1;
                fl_addr  = A_CMD;
                fl_wdata = OP_CLEAR;
            end
            S_RD_MODE: begin
                fl_we    = 1'b1;
                fl_addr  = A_CMD;
                fl_wdata = OP_READ;
            end
            S_VREAD: begin
                fl_re   = 1'b1;
                fl_addr = cur_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbp_seq_chk.sv
// Protocol checker for fbp_seq, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module fbp_seq_chk #(
    parameter int ADDR_W   = 22,
    parameter int BLK_BITS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_we,
    input logic              fl_re,
    input logic              gate_pulse,
    input logic              lane_wr,
    input logic              busy,
    input logic              done,
    input logic [BLK_BITS:0] res_count,
    input logic              res_err
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
    assert_write_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (fl_addr[1:0] == 2'b00));
    assert_bus_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));
    assert_gate_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulse |=> !gate_pulse);
    assert_lane_then_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wr |=> fl_we);
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_err) |-> (res_count == '0));
endmodule

bind fbp_seq fbp_seq_chk #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .fl_addr    (fl_addr),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .gate_pulse (gate_pulse),
    .lane_wr    (lane_wr),
    .busy       (busy),
    .done       (done),
    .res_count  (res_count),
    .res_err    (res_err)
);

// File: tb/fbp_seq_test.sv
`timescale 1ns/100ps
module fbp_seq_test;
    localparam int AW  = 17;
    localparam int BB  = 16;
    localparam int STO = 20;
    localparam int BTO = 400;
    localparam int RW  = 4;
    localparam int ST  = 3;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [BB:0]   req_count = '0;
    logic          in_valid, in_ready, src_rewind;
    logic [7:0]    in_data;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_we, fl_re, gate_pulse, lane_wr, busy, done, res_err;
    logic [1:0]    lane_val;
    logic [BB:0]   res_count;

    fbp_seq #(.ADDR_W(AW), .BLK_BITS(BB), .STAT_TO(STO), .BLK_TO(BTO),
              .RETRY_WAIT(RW), .SETTLE(ST)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .req_count(req_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .src_rewind(src_rewind), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
        .gate_pulse(gate_pulse), .lane_wr(lane_wr), .lane_val(lane_val),
        .busy(busy), .done(done), .res_count(res_count), .res_err(res_err)
    );

    // ---------------- flash model ----------------
    logic [7:0]    mem [0:(1<<AW)-1];
    logic          smode, pend, stuck, errb, gate_ok;
    logic [1:0]    lane_q;
    int            lat, n40, n50, n70, viol;
    logic          mdl_clr = 1'b0;
    int            stuck_lim = 0, err_lim = 0, corrupt_at = -1;
    logic [AW-1:0] prog_addr;
    logic [7:0]    status;

    assign prog_addr = {fl_addr[AW-1:2], lane_q};
    assign status    = {(!stuck && lat == 0), 2'b00, errb, 4'b0000};
    assign fl_rdata  = smode ? status : mem[fl_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= 8'hFF;
            smode <= 0; pend <= 0; stuck <= 0; errb <= 0; gate_ok <= 0;
            lane_q <= 0; lat <= 0; n40 <= 0; n50 <= 0; n70 <= 0; viol <= 0;
        end else begin
            if (mdl_clr) begin n40 <= 0; n50 <= 0; n70 <= 0; viol <= 0; end
            if (lat > 0) lat <= lat - 1;
            if (gate_pulse) gate_ok <= 1;
            if (lane_wr) lane_q <= lane_val;
            if (fl_re && smode && fl_addr != AW'(32'h8000)) viol <= viol + 1;
            if (fl_we) begin
                if (pend) begin
                    pend <= 0;
                    lat  <= LAT;
                    if (n40 <= stuck_lim) stuck <= 1;
                    else if (n40 <= stuck_lim + err_lim) errb <= 1;
                    else mem[prog_addr] <= (int'(prog_addr) == corrupt_at) ? (fl_wdata ^ 8'h01) : fl_wdata;
                end else begin
                    case (fl_wdata)
                        8'h40: begin
                            if (!gate_ok) viol <= viol + 1;
                            gate_ok <= 0; pend <= 1; n40 <= n40 + 1;
                        end
                        8'h70: begin
                            if (fl_addr != AW'(32'h10000)) viol <= viol + 1;
                            smode <= 1; n70 <= n70 + 1;
                        end
                        8'hFF: begin
                            if (!gate_ok || fl_addr != AW'(32'h8000)) viol <= viol + 1;
                            gate_ok <= 0; smode <= 0;
                        end
                        8'h50: begin
                            if (!gate_ok || fl_addr != AW'(32'h8000)) viol <= viol + 1;
                            gate_ok <= 0; smode <= 0; errb <= 0; stuck <= 0; n50 <= n50 + 1;
                        end
                        default: viol <= viol + 1;
                    endcase
                end
            end
        end
    end

    // ---------------- stream source ----------------
    logic       tog, gappy = 1'b0;
    logic [7:0] seed = 8'h00;
    int         ptr;

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'(i * 37) ^ s;
    endfunction

    assign in_valid = gappy ? tog : 1'b1;
    assign in_data  = pat(ptr, seed);

    always @(posedge clk) begin
        if (!rst_n || mdl_clr) begin
            ptr <= 0; tog <= 0;
        end else begin
            tog <= ~tog;
            if (src_rewind) ptr <= 0;
            else if (in_valid && in_ready) ptr <= ptr + 1;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int  rc, cyc, busy_gaps;
    logic re;

    task automatic run(input logic [AW-1:0] a, input int n);
        @(negedge clk); mdl_clr = 1;
        @(negedge clk); mdl_clr = 0; start_addr = a; req_count = (BB+1)'(n); start = 1;
        @(negedge clk); start = 0;
        cyc = 1; busy_gaps = 0;
        while (!done && cyc < 5000) begin
            if (!busy) busy_gaps++;
            @(negedge clk); cyc++;
        end
        chk(cyc < 5000, "R11 done reached", cyc, 0);
        rc = int'(res_count); re = res_err;
        chk(!busy, "R11 busy low with done", busy, 0);
        chk(busy_gaps == 0, "R11 busy held until done", busy_gaps, 0);
        @(negedge clk);
        chk(!done, "R11 done single cycle", done, 0);
    endtask

    task automatic mem_match(input logic [AW-1:0] a, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[a + AW'(i)] !== pat(i, seed)) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !in_ready && !fl_we && !fl_re, "R11 reset idle",
            {busy, done, in_ready, fl_we, fl_re}, 0);
    endtask

    task automatic t_basic();
        stuck_lim = 0; err_lim = 0; gappy = 1; seed = 8'h11;
        run(17'h10005, 7);
        chk(rc == 7 && re == 0, "R10 full match count", rc, 7);
        mem_match(17'h10005, 7, "R2 bytes at exact byte address");
        chk(viol == 0, "R3 gate and command order", viol, 0);
        chk(n70 == 7, "R4 one status command per byte", n70, 7);
        chk(n40 == 7 && n50 == 0, "R6 no clear on clean run", n50, 0);
    endtask

    task automatic t_clip();
        gappy = 0; seed = 8'h2C;
        run(17'h0FFFE, 8);
        chk(rc == 2, "R1 clipped count", rc, 2);
        chk(mem[17'h10000] == 8'hFF, "R1 next region untouched", mem[17'h10000], 8'hFF);
        mem_match(17'h0FFFE, 2, "R1 clipped bytes written");
        run(17'h0FFF0, 16);
        chk(rc == 16, "R1 exact fit not clipped", rc, 16);
    endtask

    task automatic t_timeout();
        stuck_lim = 2; err_lim = 0; seed = 8'h47;
        run(17'h00100, 3);
        chk(rc == 3 && re == 0, "R5 silent timeout retry", rc, 3);
        chk(n40 == 5, "R5 retried attempts", n40, 5);
        chk(n50 == 2, "R5 clear per timeout", n50, 2);
        chk(viol == 0, "R5 gate before clear", viol, 0);
        mem_match(17'h00100, 3, "R5 bytes after retry");
        stuck_lim = 0;
    endtask

    task automatic t_errbit();
        err_lim = 2; seed = 8'h63;
        run(17'h00203, 2);
        chk(rc == 2 && re == 0, "R7 fail bit retried", rc, 2);
        chk(n40 == 4 && n50 == 2, "R7 clear per failure", n50, 2);
        mem_match(17'h00203, 2, "R7 bytes after retry");
        err_lim = 0;
    endtask

    task automatic t_deadline();
        err_lim = 1000000; seed = 8'h0F;
        run(17'h00400, 3);
        chk(re == 1 && rc == 0, "R8 deadline error", re, 1);
        chk(cyc >= BTO && cyc < BTO + 40, "R8 deadline length", cyc, BTO);
        chk(n40 > 1, "R7 retries before deadline", n40, 2);
        err_lim = 0;
    endtask

    task automatic t_mismatch();
        corrupt_at = 32'h00302; seed = 8'hA5;
        run(17'h00300, 4);
        chk(rc == 0 && re == 0, "R9 verify mismatch", rc, 0);
        corrupt_at = -1;
    endtask

    task automatic t_zero();
        run(17'h00500, 0);
        chk(rc == 0 && re == 0 && cyc == 1, "R12 zero count immediate", cyc, 1);
        chk(n40 == 0 && n70 == 0, "R12 no flash traffic", n40, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clip();
        t_timeout();
        t_errbit();
        t_deadline();
        t_mismatch();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule